// File: doc/BRIEF.md
# Tagged Translation Look-Aside Buffer

This block holds a small set of recent virtual-to-physical page translations. Each lookup compares the page number of a virtual address against every stored entry at once. It returns the physical address, built from the stored frame number and the unchanged page offset, when an entry matches. The lookup is combinational.

Entries are tagged with an address-space ID, so a context switch does not have to empty the buffer. Each entry also carries read, write and execute permission bits, and these are checked on every hit.

A fill port installs a translation after a page-table walk, which is done outside the block. A flush port either clears every entry or clears only the entries of one address-space ID. The fill port picks its target entry in this order:
- an entry that already holds the same page for the same ID;
- otherwise, the lowest-numbered free entry;
- otherwise, the entry under a round-robin pointer.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses: lk_miss_o=1, lk_hit_o=0.
- R2: A lookup whose page number (lk_va_i[31:12]) and ID match a valid entry gives lk_hit_o=1, lk_miss_o=0 and lk_pa_o = {stored frame number, lk_va_i[11:0]} in the same cycle.
- R3: An entry whose stored ID differs from lk_asid_i never hits, even when its page number matches. Such a lookup gives lk_miss_o=1 and lk_fault_o=0.
- R4: Access type lk_acc_i is 0 for read, 1 for write and 2 for execute. Permission bits are bit0 read, bit1 write and bit2 execute. A hit whose access type has its permission bit clear raises lk_fault_o=1. A permitted hit gives lk_fault_o=0.
- R5: A fill that matches no valid entry, while some entry is invalid, writes the lowest-numbered invalid entry and leaves every other entry untouched.
- R6: A fill that matches no entry, when all entries are valid, replaces the entry under a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only after such a replacement.
- R7: Filling a page and ID that are already present overwrites that entry with the new frame number and permissions. No second entry is created and no other entry is evicted.
- R8: A flush with flush_all_i=0 invalidates exactly the entries whose ID equals flush_asid_i. Entries of other IDs keep hitting.
- R9: A flush with flush_all_i=1 invalidates all entries at the next clock edge.
- R10: When a fill and a flush occur in the same cycle, the flush acts on the existing contents. The filled entry is still valid afterwards, even if its ID is the one being flushed.
- R11: While lk_valid_i=0, lk_hit_o, lk_miss_o and lk_fault_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Virtual address to translate |
| lk_asid_i | input | 8 | Current address-space ID |
| lk_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lk_hit_o | output | 1 | A valid entry matched |
| lk_miss_o | output | 1 | Request found no entry |
| lk_fault_o | output | 1 | Hit, but the access type is not permitted |
| lk_pa_o | output | 32 | Physical address, meaningful only on a hit |
| fill_i | input | 1 | Install one translation |
| fill_vpn_i | input | 20 | Page number to install |
| fill_asid_i | input | 8 | ID of the installed translation |
| fill_pfn_i | input | 20 | Frame number to install |
| fill_perm_i | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush_i | input | 1 | Invalidate entries |
| flush_all_i | input | 1 | 1: clear all entries, 0: clear only flush_asid_i |
| flush_asid_i | input | 8 | ID cleared by a selective flush |

## Verification
Fill and flush can land on the same clock edge, and this collision is the case most likely to hide an ordering error. The bench raises both requests in one cycle in two forms.
- A selective flush of an ID together with a fill under that same ID. After the edge, the flushed page must miss and the freshly filled page must hit.
- A global flush together with a fill. Afterwards only the filled page may hit.

Every result is judged through later lookups at the ports. Placement is also judged indirectly: which older page a later round-robin eviction removes shows where earlier fills landed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;
  localparam int unsigned PERM_W_BITS = 3;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [2:0]        wr_perm_i,
  input  logic              flush_i,
  input  logic              flush_all_i,
  input  logic [ASID_W-1:0] flush_asid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_match_o,
  output logic              fill_match_o,
  output logic              valid_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [2:0]        perm_o
);
  logic              valid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [2:0]        perm_q;
  logic              kill;

  assign kill = flush_i && (flush_all_i || (asid_q == flush_asid_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else if (we_i) begin
      // fill wins over a flush in the same cycle
      valid_q <= 1'b1;
      vpn_q   <= wr_vpn_i;
      asid_q  <= wr_asid_i;
      pfn_q   <= wr_pfn_i;
      perm_q  <= wr_perm_i;
    end else if (kill) begin
      valid_q <= 1'b0;
    end
  end

  assign lk_match_o   = valid_q && (vpn_q == lk_vpn_i) && (asid_q == lk_asid_i);
  assign fill_match_o = valid_q && (vpn_q == wr_vpn_i) && (asid_q == wr_asid_i);
  assign valid_o      = valid_q;
  assign pfn_o        = pfn_q;
  assign perm_o       = perm_q;

  AST_ASID_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !flush_all_i && valid_q && asid_q == flush_asid_i && !we_i) |=> !valid_q); // R8
  AST_WRITE_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> valid_q); // R10
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] fill_match_i,
  output logic [ENTRIES-1:0] sel_o
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] inv, first_inv, rr_oh;
  logic               use_rr;

  assign inv       = ~valid_i;
  assign first_inv = inv & (~inv + ENTRIES'(1));
  assign rr_oh     = ENTRIES'(1) << rr_q;
  assign use_rr    = fill_i && (fill_match_i == '0) && (inv == '0);

  always_comb begin
    if (!fill_i)                 sel_o = '0;
    else if (fill_match_i != '0) sel_o = fill_match_i;
    else if (inv != '0)          sel_o = first_inv;
    else                         sel_o = rr_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  AST_RR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_rr |=> $stable(rr_q)); // R6
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> $onehot(sel_o)); // R5
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit #(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned ENTRIES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lk_valid_i,
  input  logic [VA_W-1:0]         lk_va_i,
  input  logic [ASID_W-1:0]       lk_asid_i,
  input  logic [1:0]              lk_acc_i,
  output logic                    lk_hit_o,
  output logic                    lk_miss_o,
  output logic                    lk_fault_o,
  output logic [PA_W-1:0]         lk_pa_o,
  input  logic                    fill_i,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn_i,
  input  logic [ASID_W-1:0]       fill_asid_i,
  input  logic [PA_W-OFF_W-1:0]   fill_pfn_i,
  input  logic [2:0]              fill_perm_i,
  input  logic                    flush_i,
  input  logic                    flush_all_i,
  input  logic [ASID_W-1:0]       flush_asid_i
);
  import tlb_pkg::*;

  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PFN_W = PA_W - OFF_W;

  logic [ENTRIES-1:0] lk_match, fill_match, valid_vec, sel;
  logic [PFN_W-1:0]   pfn_arr  [ENTRIES];
  logic [2:0]         perm_arr [ENTRIES];
  logic [VPN_W-1:0]   lk_vpn;
  logic [PFN_W-1:0]   hit_pfn;
  logic [2:0]         hit_perm;
  logic               any_match, allowed;
  acc_e               acc;

  assign lk_vpn = lk_va_i[VA_W-1:OFF_W];
  assign acc    = acc_e'(lk_acc_i);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_ent (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (sel[g]),
      .wr_vpn_i     (fill_vpn_i),
      .wr_asid_i    (fill_asid_i),
      .wr_pfn_i     (fill_pfn_i),
      .wr_perm_i    (fill_perm_i),
      .flush_i      (flush_i),
      .flush_all_i  (flush_all_i),
      .flush_asid_i (flush_asid_i),
      .lk_vpn_i     (lk_vpn),
      .lk_asid_i    (lk_asid_i),
      .lk_match_o   (lk_match[g]),
      .fill_match_o (fill_match[g]),
      .valid_o      (valid_vec[g]),
      .pfn_o        (pfn_arr[g]),
      .perm_o       (perm_arr[g])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_i       (fill_i),
    .valid_i      (valid_vec),
    .fill_match_i (fill_match),
    .sel_o        (sel)
  );

  // AND-OR mux: at most one entry matches
  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_pfn  |= pfn_arr[i]  & {PFN_W{lk_match[i]}};
      hit_perm |= perm_arr[i] & {3{lk_match[i]}};
    end
  end

  always_comb begin
    case (acc)
      ACC_READ:  allowed = hit_perm[PERM_R];
      ACC_WRITE: allowed = hit_perm[PERM_W];
      ACC_EXEC:  allowed = hit_perm[PERM_X];
      default:   allowed = 1'b0;
    endcase
  end

  assign any_match  = |lk_match;
  assign lk_hit_o   = lk_valid_i && any_match;
  assign lk_miss_o  = lk_valid_i && !any_match;
  assign lk_fault_o = lk_valid_i && any_match && !allowed;
  assign lk_pa_o    = {hit_pfn, lk_va_i[OFF_W-1:0]};

  AST_NO_DUP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match)); // R7
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o); // R4
  AST_GLOBAL_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && flush_all_i && !fill_i) |=> (valid_vec == '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_fault_o)); // R11
endmodule

// File: tb/sim_tlb_lookup_unit.sv
module sim_tlb_lookup_unit;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_va = 0;
  logic [7:0]  lk_asid = 0;
  logic [1:0]  lk_acc = 0;
  logic        hit, miss, fault;
  logic [31:0] pa;
  logic        fill = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic [7:0]  fill_asid = 0;
  logic [2:0]  fill_perm = 0;
  logic        flush = 0, flush_all = 0;
  logic [7:0]  flush_asid = 0;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tlb_lookup_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_asid_i(lk_asid), .lk_acc_i(lk_acc),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_fault_o(fault), .lk_pa_o(pa),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm),
    .flush_i(flush), .flush_all_i(flush_all), .flush_asid_i(flush_asid)
  );

  task automatic fail_if(input bit bad, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // lookup and compare; exp_pfn checked only on hit
  task automatic look(input logic [19:0] vpn, input logic [7:0] asid, input logic [1:0] acc,
                      input bit e_hit, input bit e_fault, input logic [19:0] e_pfn,
                      input string req);
    @(negedge clk);
    lk_valid = 1; lk_va = {vpn, 12'h5a7}; lk_asid = asid; lk_acc = acc;
    #1;
    fail_if(hit !== e_hit || miss !== !e_hit, req, "hit", {30'd0, hit, miss}, {30'd0, e_hit, !e_hit});
    fail_if(fault !== e_fault, req, "fault", {31'd0, fault}, {31'd0, e_fault});
    if (e_hit) fail_if(pa !== {e_pfn, 12'h5a7}, req, "pa", pa, {e_pfn, 12'h5a7});
    lk_valid = 0;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [7:0] asid,
                         input logic [19:0] pfn, input logic [2:0] perm);
    @(negedge clk);
    fill = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_perm = perm;
    @(negedge clk);
    fill = 0;
  endtask

  task automatic do_flush(input bit all, input logic [7:0] asid);
    @(negedge clk);
    flush = 1; flush_all = all; flush_asid = asid;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic t_reset;
    look(20'h12345, 8'd1, 2'd0, 0, 0, 0, "R1");
    @(negedge clk);
    lk_valid = 0; lk_va = 32'h12345000; #1;
    fail_if(hit | miss | fault, "R11", "idle outputs", {29'd0, hit, miss, fault}, 0);
  endtask

  task automatic t_basic;
    do_fill(20'h12345, 8'd1, 20'habcde, 3'b111);
    look(20'h12345, 8'd1, 2'd0, 1, 0, 20'habcde, "R2");
    look(20'h12345, 8'd2, 2'd0, 0, 0, 0, "R3");
    look(20'h12346, 8'd1, 2'd0, 0, 0, 0, "R2");
    @(negedge clk);
    lk_valid = 0; lk_va = 32'h12345000; lk_asid = 8'd1; #1;
    fail_if(hit | miss | fault, "R11", "idle after fill", {29'd0, hit, miss, fault}, 0);
  endtask

  task automatic t_perm;
    do_fill(20'h00100, 8'd1, 20'h00aaa, 3'b001);
    do_fill(20'h00200, 8'd1, 20'h00bbb, 3'b100);
    look(20'h00100, 8'd1, 2'd0, 1, 0, 20'h00aaa, "R4");
    look(20'h00100, 8'd1, 2'd1, 1, 1, 20'h00aaa, "R4");
    look(20'h00100, 8'd1, 2'd2, 1, 1, 20'h00aaa, "R4");
    look(20'h00200, 8'd1, 2'd2, 1, 0, 20'h00bbb, "R4");
    look(20'h00200, 8'd1, 2'd0, 1, 1, 20'h00bbb, "R4");
  endtask

  task automatic t_overwrite_and_rr;
    do_flush(1, 0);
    for (int i = 0; i < 8; i++) look(20'h12345 + 20'(i), 8'd1, 2'd0, 0, 0, 0, "R9");
    look(20'h00100, 8'd1, 2'd0, 0, 0, 0, "R9");
    for (int i = 0; i < 8; i++) do_fill(20'h10 + 20'(i), 8'd3, 20'h500 + 20'(i), 3'b111);
    do_fill(20'h13, 8'd3, 20'h777, 3'b111);
    look(20'h13, 8'd3, 2'd0, 1, 0, 20'h777, "R7");
    for (int i = 0; i < 8; i++)
      if (i != 3) look(20'h10 + 20'(i), 8'd3, 2'd0, 1, 0, 20'h500 + 20'(i), "R7");
    do_fill(20'h40, 8'd3, 20'h940, 3'b111);
    look(20'h10, 8'd3, 2'd0, 0, 0, 0, "R6");
    look(20'h11, 8'd3, 2'd0, 1, 0, 20'h501, "R6");
    look(20'h40, 8'd3, 2'd0, 1, 0, 20'h940, "R6");
    do_fill(20'h41, 8'd3, 20'h941, 3'b111);
    look(20'h11, 8'd3, 2'd0, 0, 0, 0, "R6");
    look(20'h12, 8'd3, 2'd0, 1, 0, 20'h502, "R6");
  endtask

  task automatic t_first_invalid;
    // rr pointer now at entry 2
    do_flush(1, 0);
    for (int i = 0; i < 8; i++)
      do_fill(20'h20 + 20'(i), (i == 3 || i == 5) ? 8'd2 : 8'd1, 20'h600 + 20'(i), 3'b111);
    do_flush(0, 8'd2);
    look(20'h23, 8'd2, 2'd0, 0, 0, 0, "R8");
    look(20'h25, 8'd2, 2'd0, 0, 0, 0, "R8");
    look(20'h24, 8'd1, 2'd0, 1, 0, 20'h604, "R8");
    do_fill(20'h60, 8'd1, 20'h660, 3'b111);
    do_fill(20'h61, 8'd1, 20'h661, 3'b111);
    do_fill(20'h62, 8'd1, 20'h662, 3'b111);
    look(20'h22, 8'd1, 2'd0, 0, 0, 0, "R5");
    for (int i = 0; i < 8; i++)
      if (i != 2 && i != 3 && i != 5) look(20'h20 + 20'(i), 8'd1, 2'd0, 1, 0, 20'h600 + 20'(i), "R5");
    look(20'h60, 8'd1, 2'd0, 1, 0, 20'h660, "R5");
    look(20'h61, 8'd1, 2'd0, 1, 0, 20'h661, "R5");
    look(20'h62, 8'd1, 2'd0, 1, 0, 20'h662, "R6");
  endtask

  task automatic t_collide;
    do_flush(1, 0);
    do_fill(20'h30, 8'd4, 20'h730, 3'b111);
    do_fill(20'h31, 8'd5, 20'h731, 3'b111);
    @(negedge clk);
    flush = 1; flush_all = 0; flush_asid = 8'd4;
    fill = 1; fill_vpn = 20'h32; fill_asid = 8'd4; fill_pfn = 20'h732; fill_perm = 3'b111;
    @(negedge clk);
    flush = 0; fill = 0;
    look(20'h30, 8'd4, 2'd0, 0, 0, 0, "R10");
    look(20'h31, 8'd5, 2'd0, 1, 0, 20'h731, "R10");
    look(20'h32, 8'd4, 2'd0, 1, 0, 20'h732, "R10");
    @(negedge clk);
    flush = 1; flush_all = 1;
    fill = 1; fill_vpn = 20'h33; fill_asid = 8'd5; fill_pfn = 20'h733; fill_perm = 3'b011;
    @(negedge clk);
    flush = 0; fill = 0;
    look(20'h31, 8'd5, 2'd0, 0, 0, 0, "R10");
    look(20'h32, 8'd4, 2'd0, 0, 0, 0, "R10");
    look(20'h33, 8'd5, 2'd1, 1, 0, 20'h733, "R10");
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_perm;
    t_overwrite_and_rr;
    t_first_invalid;
    t_collide;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule